// File: doc/BRIEF.md
# Instruction prefix tracking unit

This unit sits next to an instruction decoder. It records two kinds of one-shot prefix code and applies them to the instruction that follows. A common-bank prefix redirects that instruction's register-bank accesses to the bank selected by pointer value zero. A flag-hold prefix blocks that instruction's condition-code writes. The decoder reports each instruction start together with a three-bit class code. The unit then keeps the pending prefixes and the prefixes in force for the instruction now executing. From these it forms the register-bank address and gates the execution unit's flag-write request.

Some classes treat a pending prefix in a special way. Instructions that rewrite the condition codes through an immediate mask or a pop into the status word, and loads of the interrupt level mask, run unprefixed and pass the pending prefix on to the instruction after them. Interrupt-type instructions and return-from-interrupt ignore the prefix and discard it. Taking an interrupt drops all prefix state, so a string instruction that resumes after the interrupt runs without its prefix.

Top module: `prefix_tracker`

## Requirements
- R1: While the common-bank prefix is in force for the current instruction, `bank_addr` equals BANK_BASE + `reg_off`, whatever the value of `reg_ptr`. With the defaults this stays within 0x180 to 0x18F.
- R2: With no common-bank prefix in force, `bank_addr` equals BANK_BASE + `reg_ptr`×2^OFF_W + `reg_off`. With the defaults this is 0x180 + RP×16 + offset.
- R3: While the flag-hold prefix is in force, `flag_wr_en` is 0. Otherwise it follows `flag_wr_req`.
- R4: `insn_class` codes are 0 ordinary, 1 common-bank prefix, 2 flag-hold prefix, 3 string op, 4 flag-mask or status-pop op, 5 level-mask load, 6 interrupt or context-switch op, 7 return-from-interrupt. A start of class 1 sets `pfx_pending[0]`. A start of class 2 sets `pfx_pending[1]`. A prefix code puts no prefix in force on itself.
- R5: A start of class 4 or 5 runs with no prefix in force and leaves `pfx_pending` unchanged, so the prefix applies to the next instruction.
- R6: A start of class 6 or 7 runs with no prefix in force (flags update, normal bank address) and clears `pfx_pending`.
- R7: A start of class 0 or 3 puts the pending prefixes in force for exactly that instruction and clears `pfx_pending`. The prefixes stay in force until the next instruction start.
- R8: A high `irq_entry` clears both the pending and the in-force prefixes. A string instruction that resumes afterwards therefore runs unprefixed.
- R9: Both prefixes may be pending together, and each applies independently to the same following instruction.
- R10: Reset clears all prefix state.
- R11: When `irq_entry` and `insn_start` are high in the same cycle, the interrupt wins and the start has no effect on prefix state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_start | input | 1 | Decoder strobe: a new instruction begins this cycle |
| insn_class | input | 3 | Class code of the starting instruction (see R4) |
| reg_ptr | input | RP_W | Current register-bank pointer |
| reg_off | input | OFF_W | Register offset within a bank |
| flag_wr_req | input | 1 | Condition-code write request from the execution unit |
| irq_entry | input | 1 | Interrupt is being taken this cycle |
| bank_addr | output | ADDR_W | Effective register-bank address |
| flag_wr_en | output | 1 | Gated condition-code write enable |
| pfx_pending | output | 2 | Pending prefixes: bit 0 common-bank, bit 1 flag-hold |

## Verification
The bench builds the unit with its defaults: a 5-bit pointer, a 4-bit offset, a 24-bit address and base 0x180. These values make the full pointer range reachable, including the top bank ending at 0x37F. They also take the base's nonzero low bits through the adding variant of the address generator. Random class sequences with random pointer and offset values reach prefix chains that run through several carrying instructions. They also reach prefixes that meet interrupts and collisions between a start and an interrupt entry.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   typedef enum logic [2:0] {
      CLS_ORD      = 3'd0,
      CLS_PFX_BANK = 3'd1,
      CLS_PFX_HOLD = 3'd2,
      CLS_STRING   = 3'd3,
      CLS_FLAGOP   = 3'd4,
      CLS_LVLMASK  = 3'd5,
      CLS_INTR     = 3'd6,
      CLS_RETI     = 3'd7
   } insn_cls_t;

   typedef struct packed {
      logic hold;
      logic bank;
   } pfx_flags_t;

endpackage

// File: rtl/pfx_state.sv
module pfx_state
   import pfx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       insn_start,
   input  insn_cls_t  insn_class,
   input  logic       irq_entry,
   output pfx_flags_t pend,
   output pfx_flags_t act
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         act  <= '0;
      end else if (irq_entry) begin
         pend <= '0;
         act  <= '0;
      end else if (insn_start) begin
         unique case (insn_class)
            CLS_PFX_BANK: begin
               pend.bank <= 1'b1;
               act       <= '0;
            end
            CLS_PFX_HOLD: begin
               pend.hold <= 1'b1;
               act       <= '0;
            end
            CLS_FLAGOP, CLS_LVLMASK: begin
               act <= '0;
            end
            CLS_INTR, CLS_RETI: begin
               act  <= '0;
               pend <= '0;
            end
            default: begin
               act  <= pend;
               pend <= '0;
            end
         endcase
      end
   end

   logic start_ok;
   assign start_ok = insn_start && !irq_entry;

   assert_set_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && insn_class == CLS_PFX_BANK) |=> (pend.bank && act == '0));

   assert_set_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && insn_class == CLS_PFX_HOLD) |=> (pend.hold && act == '0));

   assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && (insn_class == CLS_FLAGOP || insn_class == CLS_LVLMASK))
      |=> (pend == $past(pend) && act == '0));

   assert_intr_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && (insn_class == CLS_INTR || insn_class == CLS_RETI))
      |=> (pend == '0 && act == '0));

   assert_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && (insn_class == CLS_ORD || insn_class == CLS_STRING))
      |=> (pend == '0 && act == $past(pend)));

   assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_entry |=> (pend == '0 && act == '0));

   assert_hold_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!insn_start && !irq_entry) |=> $stable(act));

endmodule

// File: rtl/pfx_bank_addr.sv
module pfx_bank_addr #(
   parameter int unsigned RP_W      = 5,
   parameter int unsigned OFF_W     = 4,
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned BANK_BASE = 32'h180
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              common,
   input  logic [RP_W-1:0]   reg_ptr,
   input  logic [OFF_W-1:0]  reg_off,
   output logic [ADDR_W-1:0] bank_addr
);

   localparam int unsigned IDX_W = RP_W + OFF_W;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BANK_BASE);
   localparam logic [IDX_W-1:0]  BASE_LOW = BASE_V[IDX_W-1:0];

   logic [RP_W-1:0]  ptr_eff;
   logic [IDX_W-1:0] idx;

   assign ptr_eff = common ? '0 : reg_ptr;
   assign idx     = {ptr_eff, reg_off};

   generate
      if (BASE_LOW == '0) begin : g_or_base
         assign bank_addr = BASE_V | ADDR_W'(idx);
      end else begin : g_add_base
         assign bank_addr = BASE_V + ADDR_W'(idx);
      end
   endgenerate

   logic [ADDR_W-1:0] rel;
   assign rel = bank_addr - BASE_V;

   assert_common_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      common |-> (rel < ADDR_W'(2 ** OFF_W)));

   assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rel[OFF_W-1:0] == reg_off);

endmodule

// File: rtl/pfx_flag_gate.sv
module pfx_flag_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic flag_wr_req,
   output logic flag_wr_en
);

   assign flag_wr_en = flag_wr_req & ~hold;

   assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !flag_wr_en);

endmodule

// File: rtl/prefix_tracker.sv
module prefix_tracker
   import pfx_pkg::*;
#(
   parameter int unsigned RP_W      = 5,
   parameter int unsigned OFF_W     = 4,
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned BANK_BASE = 32'h180
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_start,
   input  logic [2:0]        insn_class,
   input  logic [RP_W-1:0]   reg_ptr,
   input  logic [OFF_W-1:0]  reg_off,
   input  logic              flag_wr_req,
   input  logic              irq_entry,
   output logic [ADDR_W-1:0] bank_addr,
   output logic              flag_wr_en,
   output logic [1:0]        pfx_pending
);

   localparam int unsigned IDX_W = RP_W + OFF_W;

   generate
      if (RP_W < 1 || OFF_W < 1) begin : g_bad_width
         $error("prefix_tracker: RP_W and OFF_W must be at least 1");
      end
      if (IDX_W > ADDR_W) begin : g_bad_addr
         $error("prefix_tracker: pointer and offset exceed address width");
      end
   endgenerate

   pfx_flags_t pend;
   pfx_flags_t act;

   pfx_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_start (insn_start),
      .insn_class (insn_cls_t'(insn_class)),
      .irq_entry  (irq_entry),
      .pend       (pend),
      .act        (act)
   );

   pfx_bank_addr #(
      .RP_W      (RP_W),
      .OFF_W     (OFF_W),
      .ADDR_W    (ADDR_W),
      .BANK_BASE (BANK_BASE)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .common    (act.bank),
      .reg_ptr   (reg_ptr),
      .reg_off   (reg_off),
      .bank_addr (bank_addr)
   );

   pfx_flag_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold        (act.hold),
      .flag_wr_req (flag_wr_req),
      .flag_wr_en  (flag_wr_en)
   );

   assign pfx_pending = {pend.hold, pend.bank};

   assert_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_start && irq_entry) |=> (pfx_pending == 2'b00));

endmodule

// File: tb/prefix_tracker_bench.sv
`timescale 1ns/1ps
module prefix_tracker_bench;

   localparam int RP_W = 5, OFF_W = 4, ADDR_W = 24;
   localparam int BASE = 32'h180;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              insn_start = 1'b0;
   logic [2:0]        insn_class = 3'd0;
   logic [RP_W-1:0]   reg_ptr = '0;
   logic [OFF_W-1:0]  reg_off = '0;
   logic              flag_wr_req = 1'b0;
   logic              irq_entry = 1'b0;
   logic [ADDR_W-1:0] bank_addr;
   logic              flag_wr_en;
   logic [1:0]        pfx_pending;

   always #5 clk = ~clk;

   prefix_tracker #(.RP_W(RP_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .BANK_BASE(BASE))
   u_prefix_tracker (
      .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_class(insn_class),
      .reg_ptr(reg_ptr), .reg_off(reg_off), .flag_wr_req(flag_wr_req),
      .irq_entry(irq_entry), .bank_addr(bank_addr), .flag_wr_en(flag_wr_en),
      .pfx_pending(pfx_pending)
   );

   int checks = 0;
   int errors = 0;
   logic m_pb = 0, m_ph = 0, m_ab = 0, m_ah = 0;

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr(logic common, logic [RP_W-1:0] rp,
                                            logic [OFF_W-1:0] off);
      return BASE + (common ? 0 : 32'(rp) * (2 ** OFF_W)) + 32'(off);
   endfunction

   task automatic model(logic start, logic [2:0] cls, logic irq);
      if (irq) begin
         m_pb = 0; m_ph = 0; m_ab = 0; m_ah = 0;
      end else if (start) begin
         case (cls)
            3'd1: begin m_pb = 1; m_ab = 0; m_ah = 0; end
            3'd2: begin m_ph = 1; m_ab = 0; m_ah = 0; end
            3'd4, 3'd5: begin m_ab = 0; m_ah = 0; end
            3'd6, 3'd7: begin m_ab = 0; m_ah = 0; m_pb = 0; m_ph = 0; end
            default: begin m_ab = m_pb; m_ah = m_ph; m_pb = 0; m_ph = 0; end
         endcase
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " pending"}, 32'(pfx_pending), {30'd0, m_ph, m_pb});
      chk({tag, " addr"}, 32'(bank_addr), exp_addr(m_ab, reg_ptr, reg_off));
      chk({tag, " flag"}, 32'(flag_wr_en), 32'(flag_wr_req & ~m_ah));
   endtask

   task automatic step(logic start, logic [2:0] cls, logic irq, logic req, string tag);
      @(negedge clk);
      insn_start  = start;
      insn_class  = cls;
      irq_entry   = irq;
      flag_wr_req = req;
      reg_ptr     = RP_W'($urandom);
      reg_off     = OFF_W'($urandom);
      @(posedge clk);
      model(start, cls, irq);
      #1;
      insn_start = 0;
      irq_entry  = 0;
      check_all(tag);
   endtask

   initial begin : watchdog
      #2000000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      reg_ptr = 5'd3; reg_off = 4'd5; flag_wr_req = 1;
      #1;
      chk("R10 reset pending", 32'(pfx_pending), 0);
      chk("R2 reset addr", 32'(bank_addr), 32'h1B5);
      chk("R3 reset flag", 32'(flag_wr_en), 1);
      @(negedge clk); rst_n = 1;

      // R1 / R7: common-bank prefix on one ordinary instruction
      step(1, 3'd1, 0, 1, "R4 bank prefix");
      step(1, 3'd0, 0, 1, "R1 common bank");
      chk("R1 window", 32'(bank_addr - BASE < 16), 1);
      step(1, 3'd0, 0, 1, "R7 consumed");
      // R3
      step(1, 3'd2, 0, 1, "R4 hold prefix");
      step(1, 3'd0, 0, 1, "R3 hold");
      chk("R3 blocked", 32'(flag_wr_en), 0);
      step(0, 3'd0, 0, 1, "R7 persists till next start");
      // R9
      step(1, 3'd1, 0, 1, "R9 a");
      step(1, 3'd2, 0, 1, "R9 b");
      chk("R9 both pending", 32'(pfx_pending), 3);
      step(1, 3'd3, 0, 1, "R9 both applied");
      // R5 carry through flag op and level load
      step(1, 3'd2, 0, 1, "R5 a");
      step(1, 3'd4, 0, 1, "R5 flagop");
      chk("R5 flagop runs", 32'(flag_wr_en), 1);
      step(1, 3'd5, 0, 1, "R5 lvlmask");
      chk("R5 still pending", 32'(pfx_pending), 2);
      step(1, 3'd0, 0, 1, "R5 next gets it");
      chk("R5 applied", 32'(flag_wr_en), 0);
      // R6
      step(1, 3'd2, 0, 1, "R6 a");
      step(1, 3'd6, 0, 1, "R6 intr");
      chk("R6 intr flags", 32'(flag_wr_en), 1);
      step(1, 3'd1, 0, 1, "R6 b");
      step(1, 3'd7, 0, 1, "R6 reti");
      chk("R6 reti pending", 32'(pfx_pending), 0);
      // R8 interrupted string
      step(1, 3'd1, 0, 1, "R8 a");
      step(1, 3'd3, 0, 1, "R8 string prefixed");
      step(0, 3'd0, 1, 1, "R8 irq");
      step(1, 3'd3, 0, 1, "R8 resume unprefixed");
      // R11
      step(1, 3'd2, 0, 1, "R11 a");
      step(1, 3'd0, 1, 1, "R11 collide");
      chk("R11 flag", 32'(flag_wr_en), 1);
      // R10 mid-run reset
      step(1, 3'd1, 0, 1, "R10 a");
      @(negedge clk); rst_n = 0; #1;
      m_pb = 0; m_ph = 0; m_ab = 0; m_ah = 0;
      chk("R10 reset clears", 32'(pfx_pending), 0);
      @(negedge clk); rst_n = 1;
      // random
      for (int i = 0; i < 3000; i++) begin
         step(1'($urandom), 3'($urandom), ($urandom % 13) == 0, 1'($urandom), "R7 random");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule